// File: doc/BRIEF.md
# Automatic Level Control Gain Engine

This block steers the 6-bit gain code of a record-path amplifier from the stream of converted samples that leave that amplifier. Each valid sample strobe brings one signed sample. The block keeps a running peak magnitude and compares it with a programmable target level. It then walks the gain code down by one 0.75 dB step, or up by one step, at intervals that are counted in sample strobes.

Two behaviours are available. In level-control mode the gain is raised toward the ceiling whenever the peak stays below target. A rise waits for a programmable hold period first, and a noise gate can freeze it for very quiet input. In peak-limiter mode the gain is cut while the peak is above target, and it recovers toward the ceiling with no hold and no gate. A small write-only register bus sets the mode, the target, the time codes, the floor, the ceiling and the gate. The outputs are the gain code and a one-cycle strobe that marks every change of it.

Top module: `alc_gain_engine`

## Requirements
- R1: After reset, gain_code is 16 (0 dB) and gain_upd is low. The configuration defaults are mode 0, floor code 0, ceiling 63, target code 12, hold code 0, decay code 3, attack code 2, and gate off with threshold 0.
- R2: gain_code value g stands for -12 dB + 0.75 dB x g. It moves by at most one step per clock unless the floor or ceiling forces it. gain_upd is high for exactly the cycle after each clock edge at which gain_code changed.
- R3: The peak is the largest sample magnitude seen since the last attack or decay step, including the current sample. A magnitude is |sample|, and -32768 counts as 32767. The peak is cleared when a step is taken.
- R4: The target code k (0..15, 15 treated as 14) sets the threshold to floor(floor(32767 x M / 256) / 2^(n/4)). Here n = 15 - k, M is 256, 215, 181 or 152 for n mod 4 = 0, 1, 2 or 3, and n/4 is integer division. This covers -22.5 dB to -1.5 dB in 1.5 dB steps.
- R5: While the peak is above target, each run of ATK_BASE x 2^attack strobes lowers the gain by one step, stopping at the floor. A strobe at or below target restarts this count.
- R6: In mode 0, a strobe at or below target (and not gated) first counts hold. Decay begins only after HLD_BASE x 2^(hold-1) such strobes, or at once for hold code 0. A strobe above target restarts the hold.
- R7: Once the hold has run, each run of DCY_BASE x 2^decay strobes raises the gain by one step, stopping at the ceiling.
- R8: In mode 1 there is no hold and no gate. Decay runs on every strobe at or below target, and attack runs as in R5.
- R9: In mode 0, with the gate enabled and the peak below the gate threshold, a strobe never raises the gain and clears the hold, decay and attack counts.
- R10: The gain is held within floor = 8 x floor code and ceiling = max(ceiling code, floor). A configuration write that moves a bound pulls the gain inside it at the next clock edge.
- R11: When the mode bit changes, the hold, attack and decay counts clear at the next edge. A strobe that arrives in that cycle is discarded.
- R12: Register 0 holds mode in bit 0, floor code in bits 3:1 and ceiling code in bits 9:4. Register 1 holds target code in bits 3:0, hold in 7:4, decay in 11:8 and attack in 15:12. Register 2 holds the gate threshold in bits 14:0 and the gate enable in bit 15. Writes to address 3 have no effect.
- R13: Cycles without a sample strobe change no count and no gain, whatever smp_data carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 16 | Register write data |
| smp_vld | input | 1 | Sample strobe |
| smp_data | input | SAMPLE_W | Signed sample from the converter |
| gain_code | output | 6 | Amplifier gain code |
| gain_upd | output | 1 | One-cycle pulse after each gain change |

## Verification
A sample strobe that completes an interval changes gain_code at the very clock edge that takes it, and gain_upd rises at that same edge. A register write takes effect at its edge, so a bound clamp shows one edge later and a mode change is seen at the edge after the write. The bench keeps a behavioural model that applies these same edge counts. It compares both outputs with the model at every falling edge, and checks fixed gain values two cycles after each phase ends, when nothing is still in flight.

// File: rtl/alc_pkg.sv
package alc_pkg;

  localparam int GAIN_W = 6;
  localparam int CFG_AW = 2;
  localparam int CFG_DW = 16;
  localparam int THR_W  = CFG_DW - 1;

  typedef struct packed {
    logic             mode;
    logic [2:0]       floor_code;
    logic [GAIN_W-1:0] ceil_code;
    logic [3:0]       tgt_code;
    logic [3:0]       hld_code;
    logic [3:0]       dcy_code;
    logic [3:0]       atk_code;
    logic             gate_en;
    logic [THR_W-1:0] gate_thr;
  } alc_cfg_t;

  // strobe count of an attack or decay interval
  function automatic logic [31:0] step_interval(input logic [31:0] base,
                                                input logic [3:0]  code);
    return base << code;
  endfunction

  // hold length: zero for code 0, then doubling from base
  function automatic logic [31:0] hold_interval(input logic [31:0] base,
                                                input logic [3:0]  code);
    logic [3:0] sh;
    sh = code - 4'd1;
    return (code == 4'd0) ? 32'd0 : (base << sh);
  endfunction

  // target magnitude on a 1.5 dB ladder below full scale
  function automatic logic [31:0] target_mag(input logic [31:0] full,
                                             input logic [3:0]  code);
    logic [3:0]  k;
    logic [3:0]  n;
    logic [8:0]  mant;
    logic [47:0] prod;
    k = (code > 4'd14) ? 4'd14 : code;
    n = 4'd15 - k;
    case (n[1:0])
      2'd0:    mant = 9'd256;
      2'd1:    mant = 9'd215;
      2'd2:    mant = 9'd181;
      default: mant = 9'd152;
    endcase
    prod = 48'(full) * 48'(mant);
    prod = (prod >> 8) >> n[3:2];
    return prod[31:0];
  endfunction

  function automatic logic [GAIN_W-1:0] floor_gain(input logic [2:0] fc);
    return {fc, 3'b000};
  endfunction

  function automatic logic [GAIN_W-1:0] ceil_gain(input logic [GAIN_W-1:0] cc,
                                                  input logic [GAIN_W-1:0] lo);
    return (cc < lo) ? lo : cc;
  endfunction

  function automatic logic [GAIN_W-1:0] clamp_gain(input logic [GAIN_W-1:0] g,
                                                   input logic [GAIN_W-1:0] lo,
                                                   input logic [GAIN_W-1:0] hi);
    if (g < lo) return lo;
    if (g > hi) return hi;
    return g;
  endfunction

endpackage

// File: rtl/alc_cfg_regs.sv
module alc_cfg_regs
  import alc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output alc_cfg_t          cfg
);

  alc_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.mode       <= 1'b0;
      cfg_q.floor_code <= 3'd0;
      cfg_q.ceil_code  <= 6'd63;
      cfg_q.tgt_code   <= 4'd12;
      cfg_q.hld_code   <= 4'd0;
      cfg_q.dcy_code   <= 4'd3;
      cfg_q.atk_code   <= 4'd2;
      cfg_q.gate_en    <= 1'b0;
      cfg_q.gate_thr   <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        2'd0: begin
          cfg_q.mode       <= cfg_wdata[0];
          cfg_q.floor_code <= cfg_wdata[3:1];
          cfg_q.ceil_code  <= cfg_wdata[9:4];
        end
        2'd1: begin
          cfg_q.tgt_code <= cfg_wdata[3:0];
          cfg_q.hld_code <= cfg_wdata[7:4];
          cfg_q.dcy_code <= cfg_wdata[11:8];
          cfg_q.atk_code <= cfg_wdata[15:12];
        end
        2'd2: begin
          cfg_q.gate_thr <= cfg_wdata[THR_W-1:0];
          cfg_q.gate_en  <= cfg_wdata[CFG_DW-1];
        end
        default: ;
      endcase
    end
  end

  assign cfg = cfg_q;

endmodule

// File: rtl/alc_peak_det.sv
module alc_peak_det #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic                clr,
  output logic [SAMPLE_W-2:0] peak_now
);

  localparam int MAG_W = SAMPLE_W - 1;

  logic [SAMPLE_W-1:0] neg_s;
  logic [SAMPLE_W-1:0] abs_s;
  logic [MAG_W-1:0]    mag;
  logic [MAG_W-1:0]    peak_q;

  always_comb begin
    neg_s = -smp_data;
    abs_s = smp_data[SAMPLE_W-1] ? neg_s : smp_data;
    mag   = abs_s[SAMPLE_W-1] ? {MAG_W{1'b1}} : abs_s[MAG_W-1:0];
  end

  assign peak_now = (mag > peak_q) ? mag : peak_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    peak_q <= '0;
    else if (take) peak_q <= clr ? '0 : peak_now;
  end

  // R3
  peak_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && clr) |=> (peak_q == '0));

  // R3
  peak_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !clr) |=> (peak_q >= $past(peak_q)));

endmodule

// File: rtl/alc_interval_ctr.sv
module alc_interval_ctr #(
  parameter int CNT_W   = 24,
  parameter bit RESTART = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [CNT_W-1:0] limit,
  output logic             hit
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};

  generate
    if (RESTART) begin : g_restart
      // fires on the strobe that completes the interval, then restarts
      assign hit = adv && (cnt_inc >= {1'b0, limit});
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else if (adv) cnt_q <= hit ? '0 : cnt_inc[CNT_W-1:0];
      end
    end else begin : g_saturate
      // reports that the count has reached its limit; stays there
      assign hit = (cnt_q >= limit);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else if (adv && !hit) cnt_q <= cnt_inc[CNT_W-1:0];
      end
    end
  endgenerate

  // R11
  ctr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

endmodule

// File: rtl/alc_gain_engine.sv
module alc_gain_engine
  import alc_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int CNT_W    = 24,
  parameter int ATK_BASE = 2,
  parameter int DCY_BASE = 4,
  parameter int HLD_BASE = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_addr,
  input  logic [15:0]         cfg_wdata,
  input  logic                smp_vld,
  input  logic [SAMPLE_W-1:0] smp_data,
  output logic [5:0]          gain_code,
  output logic                gain_upd
);

  localparam int          MAG_W    = SAMPLE_W - 1;
  localparam int          MAX_MAG  = (1 << MAG_W) - 1;
  localparam logic [5:0]  GAIN_RST = 6'd16;

  alc_cfg_t cfg;

  alc_cfg_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .cfg      (cfg)
  );

  // mode tracking: a change clears the timers and drops that strobe
  logic mode_q;
  logic mode_chg;
  logic live;

  assign mode_chg = (cfg.mode != mode_q);
  assign live     = smp_vld && !mode_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= cfg.mode;
  end

  // peak tracking
  logic [MAG_W-1:0] peak_now;
  logic             step_dn;
  logic             step_up;

  alc_peak_det #(.SAMPLE_W(SAMPLE_W)) u_peak (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (live),
    .smp_data(smp_data),
    .clr     (step_dn || step_up),
    .peak_now(peak_now)
  );

  // level decisions
  logic [31:0] tgt_mag;
  logic [31:0] peak_w;
  logic        over_evt;
  logic        under_evt;
  logic        gated_evt;
  logic        hold_done;

  assign tgt_mag   = target_mag(32'(MAX_MAG), cfg.tgt_code);
  assign peak_w    = 32'(peak_now);
  assign over_evt  = live && (peak_w > tgt_mag);
  assign under_evt = live && !(peak_w > tgt_mag);
  assign gated_evt = under_evt && !cfg.mode && cfg.gate_en &&
                     (peak_w < 32'(cfg.gate_thr));

  // timer controls
  logic atk_adv, atk_clr;
  logic hold_adv, hold_clr;
  logic dcy_adv, dcy_clr;

  assign atk_adv  = over_evt;
  assign atk_clr  = mode_chg || under_evt;
  assign hold_adv = under_evt && !cfg.mode && !gated_evt && !hold_done;
  assign hold_clr = mode_chg || over_evt || gated_evt || (under_evt && cfg.mode);
  assign dcy_adv  = under_evt && !gated_evt && (cfg.mode || hold_done);
  assign dcy_clr  = mode_chg || over_evt || gated_evt ||
                    (under_evt && !cfg.mode && !hold_done);

  logic [CNT_W-1:0] atk_lim;
  logic [CNT_W-1:0] dcy_lim;
  logic [CNT_W-1:0] hold_lim;

  assign atk_lim  = CNT_W'(step_interval(32'(ATK_BASE), cfg.atk_code));
  assign dcy_lim  = CNT_W'(step_interval(32'(DCY_BASE), cfg.dcy_code));
  assign hold_lim = CNT_W'(hold_interval(32'(HLD_BASE), cfg.hld_code));

  alc_interval_ctr #(.CNT_W(CNT_W), .RESTART(1'b1)) u_atk (
    .clk(clk), .rst_n(rst_n), .clr(atk_clr), .adv(atk_adv),
    .limit(atk_lim), .hit(step_dn)
  );

  alc_interval_ctr #(.CNT_W(CNT_W), .RESTART(1'b1)) u_dcy (
    .clk(clk), .rst_n(rst_n), .clr(dcy_clr), .adv(dcy_adv),
    .limit(dcy_lim), .hit(step_up)
  );

  alc_interval_ctr #(.CNT_W(CNT_W), .RESTART(1'b0)) u_hold (
    .clk(clk), .rst_n(rst_n), .clr(hold_clr), .adv(hold_adv),
    .limit(hold_lim), .hit(hold_done)
  );

  // gain register
  logic [5:0] gain_q;
  logic [5:0] lo_g;
  logic [5:0] hi_g;
  logic [5:0] gain_step;
  logic [5:0] gain_d;
  logic       clamp_act;
  logic       upd_q;

  assign lo_g = floor_gain(cfg.floor_code);
  assign hi_g = ceil_gain(cfg.ceil_code, lo_g);

  always_comb begin
    gain_step = gain_q;
    if (step_dn && (gain_q > lo_g))      gain_step = gain_q - 6'd1;
    else if (step_up && (gain_q < hi_g)) gain_step = gain_q + 6'd1;
  end

  assign gain_d    = clamp_gain(gain_step, lo_g, hi_g);
  assign clamp_act = (gain_step < lo_g) || (gain_step > hi_g);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q <= GAIN_RST;
      upd_q  <= 1'b0;
    end else begin
      gain_q <= gain_d;
      upd_q  <= (gain_d != gain_q);
    end
  end

  assign gain_code = gain_q;
  assign gain_upd  = upd_q;

  // R10
  gain_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_code >= $past(lo_g)) && (gain_code <= $past(hi_g)));

  // R2
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clamp_act |=> ((gain_code == $past(gain_code)) ||
                    (gain_code == $past(gain_code) + 6'd1) ||
                    (gain_code == $past(gain_code) - 6'd1)));

  // R2
  upd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (gain_upd == (gain_code != $past(gain_code))));

  // R5
  attack_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (over_evt && !clamp_act) |=> (gain_code <= $past(gain_code)));

  // R6
  hold_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_adv && !clamp_act) |=> (gain_code <= $past(gain_code)));

  // R9
  gate_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gated_evt && !clamp_act) |=> (gain_code <= $past(gain_code)));

  // R11
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_chg && !clamp_act) |=> $stable(gain_code));

  // R13
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_vld && !clamp_act) |=> $stable(gain_code));

endmodule

// File: tb/test_alc_gain_engine.sv
module test_alc_gain_engine;

  localparam int ATK_B = 2;
  localparam int DCY_B = 4;
  localparam int HLD_B = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        smp_vld = 1'b0;
  logic [15:0] smp_data = '0;
  logic [5:0]  gain_code;
  logic        gain_upd;

  always #4 clk = ~clk;

  alc_gain_engine i_alc_gain_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .smp_vld(smp_vld), .smp_data(smp_data),
    .gain_code(gain_code), .gain_upd(gain_upd)
  );

  int total = 0;
  int bad = 0;
  string cur_req = "R1";
  bit cmp_on = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int m_gain, m_upd, m_peak, m_atk, m_dcy, m_hld, m_mode_q;
  int c_mode, c_floor, c_ceil, c_tgt, c_hld, c_dcy, c_atk, c_gen, c_thr;
  int t_lo, t_hi, t_mag, t_pk, t_ng, t_stp;

  function automatic int ref_target(input int code);
    int k, n, m;
    k = (code > 14) ? 14 : code;
    n = 15 - k;
    if (n % 4 == 0) m = 256;
    else if (n % 4 == 1) m = 215;
    else if (n % 4 == 2) m = 181;
    else m = 152;
    return ((32767 * m) / 256) / (1 << (n / 4));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_gain = 16; m_upd = 0; m_peak = 0; m_atk = 0; m_dcy = 0; m_hld = 0;
      m_mode_q = 0;
      c_mode = 0; c_floor = 0; c_ceil = 63; c_tgt = 12; c_hld = 0;
      c_dcy = 3; c_atk = 2; c_gen = 0; c_thr = 0;
    end else begin
      t_lo = c_floor * 8;
      t_hi = (c_ceil > t_lo) ? c_ceil : t_lo;
      t_ng = m_gain;
      if (c_mode != m_mode_q) begin
        m_atk = 0; m_dcy = 0; m_hld = 0; m_mode_q = c_mode;
      end else if (smp_vld) begin
        t_mag = $signed(smp_data);
        if (t_mag < 0) t_mag = -t_mag;
        if (t_mag > 32767) t_mag = 32767;
        t_pk = (t_mag > m_peak) ? t_mag : m_peak;
        t_stp = 0;
        if (t_pk > ref_target(c_tgt)) begin
          m_dcy = 0; m_hld = 0; m_atk++;
          if (m_atk >= ATK_B * (1 << c_atk)) begin
            m_atk = 0; t_stp = 1;
            if (t_ng > t_lo) t_ng--;
          end
        end else if (c_mode == 1) begin
          m_atk = 0; m_hld = 0; m_dcy++;
          if (m_dcy >= DCY_B * (1 << c_dcy)) begin
            m_dcy = 0; t_stp = 1;
            if (t_ng < t_hi) t_ng++;
          end
        end else if (c_gen == 1 && t_pk < c_thr) begin
          m_atk = 0; m_dcy = 0; m_hld = 0;
        end else begin
          m_atk = 0;
          if (m_hld < ((c_hld == 0) ? 0 : HLD_B * (1 << (c_hld - 1)))) begin
            m_hld++; m_dcy = 0;
          end else begin
            m_dcy++;
            if (m_dcy >= DCY_B * (1 << c_dcy)) begin
              m_dcy = 0; t_stp = 1;
              if (t_ng < t_hi) t_ng++;
            end
          end
        end
        m_peak = t_stp ? 0 : t_pk;
      end
      if (t_ng < t_lo) t_ng = t_lo;
      if (t_ng > t_hi) t_ng = t_hi;
      m_upd = (t_ng != m_gain) ? 1 : 0;
      m_gain = t_ng;
      if (cfg_we) begin
        case (cfg_addr)
          2'd0: begin c_mode = cfg_wdata[0]; c_floor = cfg_wdata[3:1]; c_ceil = cfg_wdata[9:4]; end
          2'd1: begin c_tgt = cfg_wdata[3:0]; c_hld = cfg_wdata[7:4];
                      c_dcy = cfg_wdata[11:8]; c_atk = cfg_wdata[15:12]; end
          2'd2: begin c_thr = cfg_wdata[14:0]; c_gen = cfg_wdata[15]; end
          default: ;
        endcase
      end
    end
  end

  // every-cycle comparison (R2 covers the update pulse)
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      chk({cur_req, "/R2 gain"}, gain_code, m_gain);
      chk({cur_req, "/R2 upd"}, gain_upd, m_upd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'(a); cfg_wdata = 16'(d);
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = 16'hFFFF;
  endtask

  task automatic feed(input int n, input int v, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_vld = 1'b1; smp_data = 16'(v);
      for (int j = 0; j < gap; j++) begin
        @(negedge clk);
        smp_vld = 1'b0; smp_data = 16'h7000;
      end
    end
    @(negedge clk);
    smp_vld = 1'b0; smp_data = 16'h7000;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk("R1 reset gain", gain_code, 16);
    chk("R1 reset upd", gain_upd, 0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    settle();
    chk("R1 gain after release", gain_code, 16);

    cur_req = "R12";
    wr(1, 16'h002C);          // target 12, hold 2, decay 0, attack 0
    wr(3, 16'hFFFF);          // ignored
    settle();
    chk("R12 addr3 ignored", gain_code, 16);

    cur_req = "R5";
    feed(10, 30000, 0);
    feed(2, -32768, 0);
    feed(28, 30000, 0);
    settle();
    chk("R5 attack to floor R10", gain_code, 0);

    cur_req = "R6";
    feed(30, 1000, 1);
    settle();
    chk("R6 R7 hold then decay", gain_code, 5);

    cur_req = "R13";
    repeat (12) @(negedge clk);
    chk("R13 idle no change", gain_code, 5);

    cur_req = "R9";
    wr(2, 16'h87D0);          // gate on, threshold 2000
    feed(20, 1000, 0);
    settle();
    chk("R9 gate freezes", gain_code, 5);
    feed(12, 3000, 0);
    settle();
    chk("R9 above gate rises", gain_code, 6);

    cur_req = "R10";
    wr(0, 16'h00A2);          // floor 1 -> 8, ceiling 10
    settle();
    chk("R10 floor pull-up", gain_code, 8);
    feed(20, 3000, 0);
    settle();
    chk("R10 ceiling stop", gain_code, 10);
    wr(0, 16'h0060);          // ceiling 6
    settle();
    chk("R10 ceiling pull-down", gain_code, 6);
    wr(0, 16'h006E);          // floor 7 above ceiling 6
    settle();
    chk("R10 floor wins", gain_code, 56);
    wr(0, 16'h03F0);
    settle();
    chk("R10 release", gain_code, 56);

    cur_req = "R8";
    wr(0, 16'h0281);          // limiter, ceiling 40
    settle();
    chk("R8 limiter ceiling", gain_code, 40);
    feed(10, 30000, 0);
    settle();
    chk("R8 limiter attack", gain_code, 35);
    feed(16, 1000, 0);
    settle();
    chk("R8 no hold no gate", gain_code, 39);

    cur_req = "R11";
    wr(1, 16'h003C);          // hold 3 -> 16 strobes
    wr(2, 16'h0000);
    wr(0, 16'h03F0);          // level-control mode, ceiling 63
    feed(10, 1000, 0);
    wr(0, 16'h03F1);
    wr(0, 16'h03F0);
    feed(16, 1000, 0);
    settle();
    chk("R11 hold restarted", gain_code, 39);
    feed(4, 1000, 0);
    settle();
    chk("R11 R7 decay after hold", gain_code, 40);

    cur_req = "R4";
    wr(1, 16'h000E);          // target 14, hold 0
    feed(4, 27000, 0);
    settle();
    chk("R4 code14 under", gain_code, 41);
    wr(1, 16'h000F);
    feed(4, 27000, 0);
    settle();
    chk("R4 code15 as 14", gain_code, 42);
    feed(2, 31000, 0);
    settle();
    chk("R4 code15 over", gain_code, 41);
    wr(1, 16'h0000);          // target 0 -> 2431
    feed(4, 2400, 0);
    settle();
    chk("R4 code0 under", gain_code, 42);
    feed(2, 2500, 0);
    settle();
    chk("R4 code0 over", gain_code, 41);

    cur_req = "R3";
    wr(1, 16'h000E);
    feed(2, -32768, 0);
    settle();
    chk("R3 negative full scale", gain_code, 40);
    wr(1, 16'h100E);          // attack code 1 -> 4 strobes
    feed(1, 30000, 0);
    feed(3, 1000, 0);
    settle();
    chk("R3 peak held", gain_code, 39);

    settle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule